// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block holds two timer channels that share one functional clock. Each channel has its own power-of-two prescaler, a 16-bit up-counter, a terminal value and a sticky end-of-period flag. Software reaches all of these through a simple synchronous register bus. Each channel drives its own interrupt line, which is high while its flag is set and its interrupt enable is on.

A channel counts prescaled ticks from zero up to its terminal value. In auto-reload mode it then starts again from zero. In one-shot mode it drops its own enable bit and keeps the terminal count readable. A typical driver uses one channel as a free-running time base and the other as an event timer. To arm the event timer, the driver writes a terminal value and then sets enable together with interrupt enable.

Each channel is controlled by a three-state machine:

- STOP: the channel is idle.
- RUN: the channel is counting.
- EXPIRED: a one-shot period has ended and the channel holds its count.

The transitions are:

- STOP→RUN, or EXPIRED→RUN: a control write with the enable bit set.
- RUN→STOP, or EXPIRED→STOP: a control write with the enable bit clear.
- RUN→EXPIRED: a terminal tick in one-shot mode.
- RUN→RUN: a terminal tick in auto-reload mode. The counter restarts from zero.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and both interrupt lines are low.
- R2: Channel c (0 or 1) places its registers at byte addresses 0x80*c+0x80 (control), +0x84 (status), +0x88 (terminal value) and +0x8C (count). A read of any other address, including a misaligned one, returns 0. A write to any other address changes no register.
- R3: The control register holds interrupt enable in bit 8, run enable in bit 5, one-shot select in bit 4 and the prescaler code in bits 3:0. All other bits read as 0.
- R4: A prescaler code n from 0 to 8 gives one counter tick every 2^n clocks. Codes 9 to 15 behave as code 8.
- R5: While running, the count rises by one on each tick. A tick that finds the count equal to the terminal value sets status bit 0. In auto-reload mode that tick returns the count to 0, so a period lasts terminal+1 ticks.
- R6: In one-shot mode a terminal tick clears the run-enable bit and leaves the count at the terminal value. A stopped channel keeps its count unchanged.
- R7: Writing a 1 to status bit 0 clears the flag. Writing a 0 leaves it unchanged. A terminal tick in the same cycle keeps the flag set.
- R8: A channel's interrupt line is high exactly while its status flag and its interrupt enable are both 1.
- R9: A control write to a channel that is not running resets its prescaler and counter to 0. A control write to a running channel does not disturb its count.
- R10: The count register is read-only. With a terminal value of 0xFFFF in auto-reload mode, the count passes through every value from 0 to 0xFFFF and wraps to 0.
- R11: The two channels are independent. Writes to one channel and terminal events on one channel leave the other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock shared by both channels |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 10 | Byte address of the register access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the register at bus_addr_i (combinational) |
| irq_o | output | 2 | Interrupt line of each channel |

## Verification
The bench builds the block with its default parameters: two channels, a 16-bit data path, a 10-bit address and a largest prescaler code of 8. Small terminal values bring reload, one-shot expiry, flag clearing and the irq gating into reach within a few dozen clocks, with both channels active at once. The full divide-by-256 range and the clamp of codes above 8 fit in a short window. The 16-bit width keeps a complete 0 to 0xFFFF wrap at divide-by-1 near 65 k clocks, so the bench follows it value by value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } chan_state_e;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_LOAD = 'h08;
    localparam int OFF_CNT  = 'h0C;

    localparam int BIT_IE   = 8;
    localparam int BIT_EN   = 5;
    localparam int BIT_OS   = 4;
    localparam int PRE_W    = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_MAX = 8,
    parameter int CODE_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int CNT_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

    logic [CNT_W-1:0]  pcnt_q;
    logic [CNT_W-1:0]  pcnt_d;
    logic [CODE_W-1:0] eff;
    logic [31:0]       full_mask;
    logic [CNT_W-1:0]  mask;

    // codes above the largest supported divide fold onto it
    always_comb begin
        eff       = (int'(code_i) > PRE_MAX) ? CODE_W'(PRE_MAX) : code_i;
        full_mask = (32'd1 << eff) - 32'd1;
        mask      = full_mask[CNT_W-1:0];
    end

    assign tick_o = run_i && (pcnt_q == mask);

    always_comb begin
        if (clr_i) begin
            pcnt_d = '0;
        end else if (run_i) begin
            pcnt_d = tick_o ? '0 : pcnt_q + 1'b1;
        end else begin
            pcnt_d = pcnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_d;
        end
    end

    AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (pcnt_q == '0)); // R9
    AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(pcnt_q)); // R6
    AST_PRE_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && $past(tick_o) && !$past(clr_i)) |-> (eff == '0)); // R4
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PRE_MAX = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ctrl_i,
    input  logic              wr_stat_i,
    input  logic              wr_load_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] stat_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);
    chan_state_e       state_q, state_d;
    logic              ie_q, os_q, flag_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DATA_W-1:0] load_q, cnt_q, cnt_d;
    logic              running, restart, tick, terminal;

    assign running  = (state_q == ST_RUN);
    assign restart  = wr_ctrl_i && !running;
    assign terminal = tick && (cnt_q == load_q);

    tmr_prescaler #(
        .PRE_MAX (PRE_MAX),
        .CODE_W  (PRE_W)
    ) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (running),
        .clr_i  (restart),
        .code_i (pre_q),
        .tick_o (tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (wr_ctrl_i && wdata_i[BIT_EN]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (wr_ctrl_i)                state_d = wdata_i[BIT_EN] ? ST_RUN : ST_STOP;
                else if (terminal && os_q)    state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (wr_ctrl_i)                state_d = wdata_i[BIT_EN] ? ST_RUN : ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_STOP;
        else         state_q <= state_d;
    end

    // counter datapath
    always_comb begin
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == load_q) cnt_d = os_q ? cnt_q : '0;
            else                 cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            load_q <= '0;
            ie_q   <= 1'b0;
            os_q   <= 1'b0;
            pre_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_load_i) load_q <= wdata_i;
            if (wr_ctrl_i) begin
                ie_q  <= wdata_i[BIT_IE];
                os_q  <= wdata_i[BIT_OS];
                pre_q <= wdata_i[PRE_W-1:0];
            end
            if (terminal)                     flag_q <= 1'b1;
            else if (wr_stat_i && wdata_i[0]) flag_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ctrl_o              = '0;
        ctrl_o[BIT_IE]      = ie_q;
        ctrl_o[BIT_EN]      = running;
        ctrl_o[BIT_OS]      = os_q;
        ctrl_o[PRE_W-1:0]   = pre_q;
        stat_o              = '0;
        stat_o[0]           = flag_q;
        load_o              = load_q;
        count_o             = cnt_q;
        irq_o               = flag_q && ie_q;
    end

    AST_FLAG_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        terminal |=> stat_o[0]); // R5
    AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (terminal && os_q && !wr_ctrl_i) |=> (!ctrl_o[BIT_EN] && cnt_q == $past(cnt_q))); // R6
    AST_STOPPED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running && !wr_ctrl_i) |=> $stable(cnt_q)); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat_i && wdata_i[0] && !terminal) |=> !stat_o[0]); // R7
    AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart |=> (cnt_q == '0)); // R9
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ctrl_i && !wdata_i[BIT_IE]) |=> !irq_o); // R8
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
    import tmr_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int STRIDE_LOG2 = 7
) (
    input  logic                           bus_wr_i,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    output logic [DATA_W-1:0]              bus_rdata_o,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ctrl_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  stat_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  load_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  count_i,
    output logic [NUM_CH-1:0]              wr_ctrl_o,
    output logic [NUM_CH-1:0]              wr_stat_o,
    output logic [NUM_CH-1:0]              wr_load_o
);
    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0]       slot;
    logic [STRIDE_LOG2-1:0] off;
    logic [NUM_CH-1:0]      hit;
    logic [NUM_CH-1:0][DATA_W-1:0] rd_each;

    assign slot = bus_addr_i[ADDR_W-1:STRIDE_LOG2];
    assign off  = bus_addr_i[STRIDE_LOG2-1:0];

    // slot 0 is unused; channel c lives in slot c+1
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign hit[c]       = (slot == IDX_W'(c + 1));
        assign wr_ctrl_o[c] = bus_wr_i && hit[c] && (off == STRIDE_LOG2'(OFF_CTRL));
        assign wr_stat_o[c] = bus_wr_i && hit[c] && (off == STRIDE_LOG2'(OFF_STAT));
        assign wr_load_o[c] = bus_wr_i && hit[c] && (off == STRIDE_LOG2'(OFF_LOAD));

        always_comb begin
            rd_each[c] = '0;
            if (hit[c]) begin
                unique case (off)
                    STRIDE_LOG2'(OFF_CTRL): rd_each[c] = ctrl_i[c];
                    STRIDE_LOG2'(OFF_STAT): rd_each[c] = stat_i[c];
                    STRIDE_LOG2'(OFF_LOAD): rd_each[c] = load_i[c];
                    STRIDE_LOG2'(OFF_CNT):  rd_each[c] = count_i[c];
                    default:                rd_each[c] = '0;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) bus_rdata_o = bus_rdata_o | rd_each[c];
    end

    AST_ONE_STROBE: assert final ($onehot0({wr_ctrl_o, wr_stat_o, wr_load_o})); // R2
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 10,
    parameter int STRIDE_LOG2 = 7,
    parameter int PRE_MAX     = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o
);
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_v, stat_v, load_v, count_v;
    logic [NUM_CH-1:0]             wr_ctrl, wr_stat, wr_load;

    tmr_regbus #(
        .NUM_CH      (NUM_CH),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_bus (
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_rdata_o (bus_rdata_o),
        .ctrl_i      (ctrl_v),
        .stat_i      (stat_v),
        .load_i      (load_v),
        .count_i     (count_v),
        .wr_ctrl_o   (wr_ctrl),
        .wr_stat_o   (wr_stat),
        .wr_load_o   (wr_load)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_channel #(
            .DATA_W  (DATA_W),
            .PRE_MAX (PRE_MAX)
        ) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_ctrl_i (wr_ctrl[c]),
            .wr_stat_i (wr_stat[c]),
            .wr_load_i (wr_load[c]),
            .wdata_i   (bus_wdata_i),
            .ctrl_o    (ctrl_v[c]),
            .stat_o    (stat_v[c]),
            .load_o    (load_v[c]),
            .count_o   (count_v[c]),
            .irq_o     (irq_o[c])
        );

        AST_OTHER_CH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!wr_ctrl[c] && !wr_load[c] && !ctrl_v[c][5]) |=> $stable(load_v[c])); // R11
    end
endmodule

// File: tb/dual_tick_timer_tb.sv
module dual_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    dual_tick_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // behavioural reference model
    int m_ie[2], m_os[2], m_pre[2], m_run[2], m_cnt[2], m_pc[2], m_flag[2], m_load[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ie[c] = 0; m_os[c] = 0; m_pre[c] = 0; m_run[c] = 0;
                m_cnt[c] = 0; m_pc[c] = 0; m_flag[c] = 0; m_load[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int base, eff, tk, term, wrc, wrs, wrl, d;
                base = 'h80 + c * 'h80;
                d    = bus_wdata;
                wrc  = bus_wr && (bus_addr == base);
                wrs  = bus_wr && (bus_addr == base + 4);
                wrl  = bus_wr && (bus_addr == base + 8);
                eff  = (m_pre[c] > 8) ? 8 : m_pre[c];
                tk   = m_run[c] && (m_pc[c] == (1 << eff) - 1);
                term = tk && (m_cnt[c] == m_load[c]);
                if (wrc && !m_run[c])       begin m_pc[c] = 0; m_cnt[c] = 0; end
                else begin
                    if (m_run[c]) m_pc[c] = tk ? 0 : m_pc[c] + 1;
                    if (tk) begin
                        if (term) m_cnt[c] = m_os[c] ? m_cnt[c] : 0;
                        else      m_cnt[c] = (m_cnt[c] + 1) % 65536;
                    end
                end
                if (term)                 m_flag[c] = 1;
                else if (wrs && d[0])     m_flag[c] = 0;
                if (wrc)                  m_run[c] = d[5];
                else if (term && m_os[c]) m_run[c] = 0;
                if (wrc) begin m_ie[c] = d[8]; m_os[c] = d[4]; m_pre[c] = d & 'hF; end
                if (wrl) m_load[c] = d;
            end
        end
    end

    function automatic int exp_read(int a);
        for (int c = 0; c < 2; c++) begin
            int base = 'h80 + c * 'h80;
            if (a == base)     return (m_ie[c] << 8) | (m_run[c] << 5) | (m_os[c] << 4) | m_pre[c];
            if (a == base + 4) return m_flag[c];
            if (a == base + 8) return m_load[c];
            if (a == base + 12) return m_cnt[c];
        end
        return 0;
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            int e;
            e = exp_read(int'(bus_addr));
            checks++;
            if (int'(bus_rdata) != e) begin
                fails++;
                $display("FAIL %s addr=%h rdata actual=%h expected=%h", cur_req, bus_addr, bus_rdata, e[15:0]);
            end
            for (int c = 0; c < 2; c++) begin
                checks++;
                if (irq[c] != (m_flag[c] && m_ie[c])) begin
                    fails++;
                    $display("FAIL %s irq%0d actual=%b expected=%b", cur_req, c, irq[c], m_flag[c] && m_ie[c]);
                end
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic watch(input logic [9:0] a, input int n);
        bus_addr = a;
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // explicit check of an exact value at the ports
    task automatic expect_rd(input logic [9:0] a, input logic [15:0] v, input string req);
        bus_addr = a;
        @(negedge clk);
        checks++;
        if (bus_rdata !== v) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, v);
        end
        @(posedge clk); #2;
    endtask

    initial begin
        #200_000_0;
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 16; o += 4)
                expect_rd(10'('h80 + c * 'h80 + o), 16'h0, "R1");

        // R3 field layout, channel stays stopped
        cur_req = "R3";
        wr(10'h080, 16'hFFDF);
        expect_rd(10'h080, 16'h011F, "R3");

        // R5 R4 R11: ch0 auto-reload /4, ch1 one-shot /1 in parallel
        cur_req = "R5";
        wr(10'h088, 16'd5);
        wr(10'h080, 16'h0122);
        cur_req = "R6";
        wr(10'h108, 16'd3);
        wr(10'h100, 16'h0130);
        watch(10'h18C, 12);
        expect_rd(10'h100, 16'h0110, "R6");
        expect_rd(10'h10C, 16'h0003, "R6");
        cur_req = "R11";
        watch(10'h08C, 60);

        // R7 clear semantics on ch1
        cur_req = "R7";
        expect_rd(10'h104, 16'h0001, "R7");
        wr(10'h104, 16'h0000);
        expect_rd(10'h104, 16'h0001, "R7");
        wr(10'h104, 16'h0001);
        expect_rd(10'h104, 16'h0000, "R7");
        cur_req = "R8";
        wr(10'h100, 16'h0010);
        watch(10'h084, 30);

        // R9 reprogram running ch0 keeps count, then stop and restart
        cur_req = "R9";
        wr(10'h080, 16'h0121);
        watch(10'h08C, 20);
        wr(10'h080, 16'h0100);
        watch(10'h08C, 10);
        wr(10'h080, 16'h0120);
        expect_rd(10'h08C, 16'h0000, "R9");
        watch(10'h08C, 30);
        wr(10'h084, 16'h0001);

        // R4 clamp: code 12 acts as /256 on ch1
        cur_req = "R4";
        wr(10'h108, 16'd1);
        wr(10'h100, 16'h012C);
        watch(10'h10C, 1100);

        // R2 undefined and misaligned addresses, R10 read-only count
        cur_req = "R2";
        wr(10'h000, 16'hFFFF);
        wr(10'h180, 16'hFFFF);
        wr(10'h08A, 16'hFFFF);
        expect_rd(10'h000, 16'h0000, "R2");
        expect_rd(10'h090, 16'h0000, "R2");
        expect_rd(10'h180, 16'h0000, "R2");
        expect_rd(10'h082, 16'h0000, "R2");
        expect_rd(10'h088, 16'h0005, "R2");
        cur_req = "R10";
        wr(10'h100, 16'h0000);
        wr(10'h10C, 16'h1234);
        expect_rd(10'h10C, 16'h0000, "R10");
        wr(10'h108, 16'hFFFF);
        wr(10'h100, 16'h0020);
        watch(10'h10C, 65600);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule